// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block produces the source operand of a two-operand ALU instruction. Decode hands it an addressing-mode code, two register numbers, a constant field, an absolute address and an operand-size selector. The block reads a small internal register file, computes the effective address, and issues reads on a single memory port. It returns the operand with a `done` pulse. When a mode moves the base register on its own, the block also reports and applies the new base-register value.

Modes that need no memory finish in the same cycle as `start`. Memory modes first latch the effective address, then issue one or two single-cycle read requests. Each request waits for a response of any latency. An external write port loads the register file. An unknown mode code is flagged at once and has no other effect.

Top module: `oag_operand_gen`

## Requirements
- R1: After reset `done`, `illegal`, `memReq` and `wbEn` are low, and every register of the file reads as zero.
- R2: Mode code 0 (register direct) raises `done` in the same cycle as `start`, with `operand` equal to the register named by `regA`, and issues no memory request.
- R3: Mode code 1 (immediate) raises `done` in the same cycle as `start`, with `operand` equal to `constField`, and issues no memory request.
- R4: Mode code 2 (displacement) issues one read at `constField` plus register `regA`, and returns the read data as the operand.
- R5: Mode code 3 (register indirect) issues one read at the address held in register `regA`.
- R6: Mode code 4 (indexed) issues one read at the sum of registers `regA` and `regB`.
- R7: Mode code 5 (absolute) issues one read at `absAddr`.
- R8: Mode code 6 (memory indirect) reads at register `regA`, then issues a second read at the data returned by the first. The second read's data is the operand.
- R9: Mode code 7 (post-increment) reads at register `regA`. In the `done` cycle it pulses `wbEn`, with `wbIdx` = `regA` and `wbData` = old value + d, and the register takes that value. The step d is 1 shifted left by `sizeLog2` (1, 2, 4 or 8).
- R10: Mode code 8 (post-decrement) behaves like R9, except that d is subtracted.
- R11: Mode code 9 (scaled) issues one read at `constField` + register `regA` + register `regB` × d.
- R12: Mode codes 10 to 15 pulse `illegal` in the `start` cycle. They raise no `done`, issue no request and change no register.
- R13: `start` is ignored while a memory-mode operation is in progress.
- R14: Every read request is a one-cycle `memReq` pulse. `done` rises exactly one cycle after the cycle in which the final `memRspValid` is seen. All address arithmetic wraps modulo 2^DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin operand generation |
| modeCode | input | 4 | Addressing-mode code |
| regA | input | IDX_W | Base register number |
| regB | input | IDX_W | Index register number |
| constField | input | DATA_W | Immediate value or displacement |
| absAddr | input | DATA_W | Absolute address |
| sizeLog2 | input | 2 | log2 of operand size d |
| regWrEn | input | 1 | External register write enable |
| regWrIdx | input | IDX_W | External write register number |
| regWrData | input | DATA_W | External write data |
| memReq | output | 1 | Memory read request pulse |
| memAddr | output | DATA_W | Memory read address |
| memRspValid | input | 1 | Memory read data valid |
| memRdata | input | DATA_W | Memory read data |
| done | output | 1 | Operand valid pulse |
| operand | output | DATA_W | Source operand |
| illegal | output | 1 | Unknown mode code pulse |
| wbEn | output | 1 | Base-register update pulse |
| wbIdx | output | IDX_W | Updated register number |
| wbData | output | DATA_W | New base-register value |

## Verification
Every mode code runs against a register file holding values that differ from one another. A wrong register selection or a missing addend therefore shows up in both the request address and the returned data. The memory model returns a nonlinear function of the address, so a read at the wrong address cannot match by chance. Response latencies of one to four cycles separate the `done` timing from the request timing. The step size takes all four values, and some cases wrap past zero, which exposes a wrong shift, a wrong sign or a missing carry wrap. Memory-indirect cases check the count of requests and the address of the second one. Illegal codes and a `start` that arrives mid-operation are checked for side effects by reading the register back and counting requests.

// File: rtl/oag_pkg.sv
package oag_pkg;

  typedef enum logic [3:0] {
    AM_REG    = 4'd0,
    AM_IMM    = 4'd1,
    AM_DISP   = 4'd2,
    AM_RIND   = 4'd3,
    AM_IDX    = 4'd4,
    AM_ABS    = 4'd5,
    AM_MIND   = 4'd6,
    AM_AINC   = 4'd7,
    AM_ADEC   = 4'd8,
    AM_SCALED = 4'd9
  } addrMode_e;

  // strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic passDirect;       // operand comes from register/immediate path
    logic selImm;           // direct path picks the constant field
    logic captureAddr;      // latch effective address, base index, step
    logic loadAddrFromRsp;  // first hop of memory indirect: data becomes address
    logic loadOperand;      // latch final read data
    logic regUpdate;        // write back stepped base register
    logic stepDown;         // subtract the step instead of adding
  } ctrlStrobes_t;

  function automatic logic modeLegal(input logic [3:0] m);
    return m <= AM_SCALED;
  endfunction

  function automatic logic modeDirect(input logic [3:0] m);
    return (m == AM_REG) || (m == AM_IMM);
  endfunction

endpackage

// File: rtl/oag_regfile.sv
module oag_regfile #(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 8,
  parameter int IDX_W   = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic [IDX_W-1:0]  rdIdxC,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] rdDataC,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData
);

  logic [DATA_W-1:0] regs [REG_CNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
    end else if (wrEn) begin
      regs[wrIdx] <= wrData;
    end
  end

  assign rdDataA = regs[rdIdxA];
  assign rdDataB = regs[rdIdxB];
  assign rdDataC = regs[rdIdxC];

endmodule

// File: rtl/oag_datapath.sv
module oag_datapath
  import oag_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 8,
  parameter int IDX_W   = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        modeCode,
  input  logic [IDX_W-1:0]  regA,
  input  logic [IDX_W-1:0]  regB,
  input  logic [DATA_W-1:0] constField,
  input  logic [DATA_W-1:0] absAddr,
  input  logic [1:0]        sizeLog2,
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regWrIdx,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] memRdata,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] operand,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [DATA_W-1:0] wbData
);

  logic [DATA_W-1:0] valA, valB, valBase;
  logic [DATA_W-1:0] addrReg, operandReg, stepReg;
  logic [DATA_W-1:0] effAddr, stepNow, scaledIdx;
  logic [IDX_W-1:0]  baseIdxReg;
  logic              rfWrEn;
  logic [IDX_W-1:0]  rfWrIdx;
  logic [DATA_W-1:0] rfWrData;

  // internal base update takes priority over the external load port
  always_comb begin
    if (strobes.regUpdate) begin
      rfWrEn   = 1'b1;
      rfWrIdx  = baseIdxReg;
      rfWrData = wbData;
    end else begin
      rfWrEn   = regWrEn;
      rfWrIdx  = regWrIdx;
      rfWrData = regWrData;
    end
  end

  oag_regfile #(
    .DATA_W (DATA_W),
    .REG_CNT(REG_CNT),
    .IDX_W  (IDX_W)
  ) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .rdIdxA (regA),
    .rdIdxB (regB),
    .rdIdxC (baseIdxReg),
    .rdDataA(valA),
    .rdDataB(valB),
    .rdDataC(valBase),
    .wrEn   (rfWrEn),
    .wrIdx  (rfWrIdx),
    .wrData (rfWrData)
  );

  assign stepNow   = DATA_W'(1) << sizeLog2;
  assign scaledIdx = valB << sizeLog2;

  always_comb begin
    case (modeCode)
      AM_DISP:   effAddr = constField + valA;
      AM_IDX:    effAddr = valA + valB;
      AM_ABS:    effAddr = absAddr;
      AM_SCALED: effAddr = constField + valA + scaledIdx;
      default:   effAddr = valA;  // register indirect, memory indirect, auto step
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrReg    <= '0;
      operandReg <= '0;
      stepReg    <= '0;
      baseIdxReg <= '0;
    end else begin
      if (strobes.captureAddr) begin
        addrReg    <= effAddr;
        stepReg    <= stepNow;
        baseIdxReg <= regA;
      end else if (strobes.loadAddrFromRsp) begin
        addrReg <= memRdata;
      end
      if (strobes.loadOperand) operandReg <= memRdata;
    end
  end

  assign wbData  = strobes.stepDown ? (valBase - stepReg) : (valBase + stepReg);
  assign wbIdx   = baseIdxReg;
  assign memAddr = addrReg;

  always_comb begin
    if (!strobes.passDirect)  operand = operandReg;
    else if (strobes.selImm)  operand = constField;
    else                      operand = valA;
  end

endmodule

// File: rtl/oag_control.sv
module oag_control
  import oag_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   modeCode,
  input  logic         memRspValid,
  output ctrlStrobes_t strobes,
  output logic         memReq,
  output logic         done,
  output logic         illegal
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FIN} ctrlState_e;

  ctrlState_e state, stateNext;
  logic [3:0] modeReg;
  logic       secondHop, secondHopNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      modeReg   <= '0;
      secondHop <= 1'b0;
    end else begin
      state     <= stateNext;
      secondHop <= secondHopNext;
      if (strobes.captureAddr) modeReg <= modeCode;
    end
  end

  always_comb begin
    stateNext     = state;
    secondHopNext = secondHop;
    strobes       = '0;
    memReq        = 1'b0;
    done          = 1'b0;
    illegal       = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (!modeLegal(modeCode)) begin
            illegal = 1'b1;
          end else if (modeDirect(modeCode)) begin
            done               = 1'b1;
            strobes.passDirect = 1'b1;
            strobes.selImm     = (modeCode == AM_IMM);
          end else begin
            strobes.captureAddr = 1'b1;
            secondHopNext       = 1'b0;
            stateNext           = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        memReq    = 1'b1;
        stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          if ((modeReg == AM_MIND) && !secondHop) begin
            strobes.loadAddrFromRsp = 1'b1;
            secondHopNext           = 1'b1;
            stateNext               = ST_ISSUE;
          end else begin
            strobes.loadOperand = 1'b1;
            stateNext           = ST_FIN;
          end
        end
      end
      ST_FIN: begin
        done              = 1'b1;
        strobes.regUpdate = (modeReg == AM_AINC) || (modeReg == AM_ADEC);
        strobes.stepDown  = (modeReg == AM_ADEC);
        stateNext         = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/oag_operand_gen.sv
module oag_operand_gen
  import oag_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 8,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        modeCode,
  input  logic [IDX_W-1:0]  regA,
  input  logic [IDX_W-1:0]  regB,
  input  logic [DATA_W-1:0] constField,
  input  logic [DATA_W-1:0] absAddr,
  input  logic [1:0]        sizeLog2,
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regWrIdx,
  input  logic [DATA_W-1:0] regWrData,
  output logic              memReq,
  output logic [DATA_W-1:0] memAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRdata,
  output logic              done,
  output logic [DATA_W-1:0] operand,
  output logic              illegal,
  output logic              wbEn,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [DATA_W-1:0] wbData
);

  ctrlStrobes_t strobes;

  oag_control u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .modeCode   (modeCode),
    .memRspValid(memRspValid),
    .strobes    (strobes),
    .memReq     (memReq),
    .done       (done),
    .illegal    (illegal)
  );

  oag_datapath #(
    .DATA_W (DATA_W),
    .REG_CNT(REG_CNT),
    .IDX_W  (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .modeCode  (modeCode),
    .regA      (regA),
    .regB      (regB),
    .constField(constField),
    .absAddr   (absAddr),
    .sizeLog2  (sizeLog2),
    .regWrEn   (regWrEn),
    .regWrIdx  (regWrIdx),
    .regWrData (regWrData),
    .memRdata  (memRdata),
    .strobes   (strobes),
    .memAddr   (memAddr),
    .operand   (operand),
    .wbIdx     (wbIdx),
    .wbData    (wbData)
  );

  assign wbEn = strobes.regUpdate;

endmodule

// File: rtl/oag_operand_gen_chk.sv
module oag_operand_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic done,
  input logic illegal,
  input logic memReq,
  input logic wbEn
);

  // R12
  illegal_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !done);

  // R12
  illegal_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !memReq);

  // R12
  illegal_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !wbEn);

  // R14
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |=> !memReq);

  // R14
  req_not_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> !done);

  // R9
  wb_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbEn |-> done);

endmodule

bind oag_operand_gen oag_operand_gen_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .done   (done),
  .illegal(illegal),
  .memReq (memReq),
  .wbEn   (wbEn)
);

// File: tb/oag_operand_gen_tb.sv
module oag_operand_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int RC = 8;
  localparam int IW = 3;

  typedef struct packed {
    logic [3:0]    mode;
    logic [IW-1:0] ra;
    logic [IW-1:0] rb;
    logic [DW-1:0] cst;
    logic [DW-1:0] abs;
    logic [1:0]    sz;
    logic [3:0]    lat;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{4'd0, 3'd3, 3'd0, 16'h0000, 16'h0000, 2'd0, 4'd1},
    '{4'd1, 3'd0, 3'd0, 16'h1234, 16'h0000, 2'd0, 4'd1},
    '{4'd2, 3'd1, 3'd0, 16'h0020, 16'h0000, 2'd0, 4'd1},
    '{4'd2, 3'd4, 3'd0, 16'h0005, 16'h0000, 2'd0, 4'd2},
    '{4'd3, 3'd3, 3'd0, 16'h0000, 16'h0000, 2'd0, 4'd3},
    '{4'd4, 3'd1, 3'd2, 16'h0000, 16'h0000, 2'd0, 4'd1},
    '{4'd5, 3'd0, 3'd0, 16'h0000, 16'h0777, 2'd0, 4'd2},
    '{4'd6, 3'd5, 3'd0, 16'h0000, 16'h0000, 2'd0, 4'd1},
    '{4'd6, 3'd2, 3'd0, 16'h0000, 16'h0000, 2'd0, 4'd3},
    '{4'd7, 3'd1, 3'd0, 16'h0000, 16'h0000, 2'd2, 4'd1},
    '{4'd8, 3'd3, 3'd0, 16'h0000, 16'h0000, 2'd3, 4'd2},
    '{4'd9, 3'd1, 3'd2, 16'h0004, 16'h0000, 2'd1, 4'd1},
    '{4'd9, 3'd5, 3'd6, 16'hFFF0, 16'h0000, 2'd0, 4'd4},
    '{4'd7, 3'd4, 3'd0, 16'h0000, 16'h0000, 2'd1, 4'd1},
    '{4'd8, 3'd0, 3'd0, 16'h0000, 16'h0000, 2'd0, 4'd2},
    '{4'd0, 3'd1, 3'd0, 16'h0000, 16'h0000, 2'd0, 4'd1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    modeCode = '0;
  logic [IW-1:0] regA = '0, regB = '0;
  logic [DW-1:0] constField = '0, absAddr = '0;
  logic [1:0]    sizeLog2 = '0;
  logic          regWrEn = 1'b0;
  logic [IW-1:0] regWrIdx = '0;
  logic [DW-1:0] regWrData = '0;
  logic          memReq;
  logic [DW-1:0] memAddr;
  logic          memRspValid = 1'b0;
  logic [DW-1:0] memRdata = '0;
  logic          done, illegal, wbEn;
  logic [DW-1:0] operand, wbData;
  logic [IW-1:0] wbIdx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int memLat = 1;
  int reqCount = 0;
  int lastRspCyc = 0;
  logic [DW-1:0] addrLog [2];
  logic [DW-1:0] sh [RC];
  bit finished = 0;

  oag_operand_gen #(.DATA_W(DW), .REG_CNT(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .modeCode(modeCode),
    .regA(regA), .regB(regB), .constField(constField), .absAddr(absAddr),
    .sizeLog2(sizeLog2), .regWrEn(regWrEn), .regWrIdx(regWrIdx),
    .regWrData(regWrData), .memReq(memReq), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRdata(memRdata), .done(done),
    .operand(operand), .illegal(illegal), .wbEn(wbEn), .wbIdx(wbIdx),
    .wbData(wbData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] memFn(input logic [DW-1:0] a);
    return (a * 16'd3) ^ 16'hA5C3;
  endfunction

  function automatic string reqTag(input logic [3:0] m);
    case (m)
      4'd0: return "R2"; 4'd1: return "R3"; 4'd2: return "R4";
      4'd3: return "R5"; 4'd4: return "R6"; 4'd5: return "R7";
      4'd6: return "R8"; 4'd7: return "R9"; 4'd8: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: answers each request after memLat cycles in the wait state
  initial begin
    @(negedge clk);
    forever begin
      if (memReq === 1'b1) begin
        if (reqCount < 2) addrLog[reqCount] = memAddr;
        reqCount++;
        @(negedge clk);
        repeat (memLat - 1) @(negedge clk);
        memRspValid = 1'b1;
        memRdata    = memFn(addrLog[(reqCount > 2) ? 1 : reqCount - 1]);
        lastRspCyc  = cyc;
        @(negedge clk);
        memRspValid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic wrReg(input int idx, input logic [DW-1:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regWrIdx = IW'(idx); regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
    sh[idx] = val;
  endtask

  task automatic drive(input vec_t v);
    modeCode = v.mode; regA = v.ra; regB = v.rb;
    constField = v.cst; absAddr = v.abs; sizeLog2 = v.sz;
    memLat = int'(v.lat);
  endtask

  task automatic waitDone(output bit seen);
    seen = 0;
    for (int k = 0; k < 60; k++) begin
      if (done === 1'b1) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic runVec(input vec_t v);
    string t;
    logic [DW-1:0] ea, expOp, d, oldBase;
    int expReq;
    bit seen;
    t = reqTag(v.mode);
    d = DW'(1) << v.sz;
    case (v.mode)
      4'd2: ea = v.cst + sh[v.ra];
      4'd4: ea = sh[v.ra] + sh[v.rb];
      4'd5: ea = v.abs;
      4'd9: ea = v.cst + sh[v.ra] + (sh[v.rb] << v.sz);
      default: ea = sh[v.ra];
    endcase
    expReq = (v.mode == 4'd6) ? 2 : 1;
    expOp  = (v.mode == 4'd6) ? memFn(memFn(ea)) : memFn(ea);
    oldBase = sh[v.ra];
    @(negedge clk);
    reqCount = 0;
    drive(v);
    start = 1'b1;
    if (v.mode <= 4'd1) begin
      #1;
      check({t, " direct done same cycle"}, 32'(done), 32'd1);
      check({t, " direct operand"}, 32'(operand), (v.mode == 4'd1) ? 32'(v.cst) : 32'(sh[v.ra]));
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check({t, " direct no memory request"}, 32'(reqCount), 32'd0);
    end else begin
      @(negedge clk);
      start = 1'b0;
      waitDone(seen);
      check({t, " done seen"}, 32'(seen), 32'd1);
      check({t, " operand"}, 32'(operand), 32'(expOp));
      check({t, " request count"}, 32'(reqCount), 32'(expReq));
      check({t, " first address"}, 32'(addrLog[0]), 32'(ea));
      if (v.mode == 4'd6)
        check("R8 second address from first data", 32'(addrLog[1]), 32'(memFn(ea)));
      check("R14 done one cycle after response", 32'(cyc), 32'(lastRspCyc + 1));
      if (v.mode == 4'd7 || v.mode == 4'd8) begin
        logic [DW-1:0] nb;
        nb = (v.mode == 4'd7) ? oldBase + d : oldBase - d;
        check({t, " wbEn"}, 32'(wbEn), 32'd1);
        check({t, " wbIdx"}, 32'(wbIdx), 32'(v.ra));
        check({t, " wbData"}, 32'(wbData), 32'(nb));
        sh[v.ra] = nb;
      end else begin
        check({t, " no base update"}, 32'(wbEn), 32'd0);
      end
    end
  endtask

  task automatic readReg(input int idx, input string tag, input logic [DW-1:0] exp);
    @(negedge clk);
    modeCode = 4'd0; regA = IW'(idx); start = 1'b1;
    #1;
    check(tag, 32'(operand), 32'(exp));
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen;
    for (int i = 0; i < RC; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 done low", 32'(done), 32'd0);
    check("R1 illegal low", 32'(illegal), 32'd0);
    check("R1 memReq low", 32'(memReq), 32'd0);
    check("R1 wbEn low", 32'(wbEn), 32'd0);
    readReg(6, "R1 register reset value", 16'h0000);

    wrReg(1, 16'h0100);
    wrReg(2, 16'h0010);
    wrReg(3, 16'h0200);
    wrReg(4, 16'hFFFE);
    wrReg(5, 16'h0040);
    wrReg(6, 16'h8001);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i]);

    // R10 decrement below zero wraps (register 0 was 0, stepped by 1 in table)
    readReg(0, "R10 wrapped decrement value", 16'hFFFF);
    // R9 increment wraps to zero (register 4 was FFFE, stepped by 2)
    readReg(4, "R9 wrapped increment value", 16'h0000);

    // R12 unknown mode codes
    for (int m = 10; m < 16; m++) begin
      @(negedge clk);
      reqCount = 0;
      modeCode = 4'(m); regA = 3'd3; sizeLog2 = 2'd3; start = 1'b1;
      #1;
      check("R12 illegal flagged", 32'(illegal), 32'd1);
      check("R12 no done on illegal", 32'(done), 32'd0);
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      check("R12 no request on illegal", 32'(reqCount), 32'd0);
    end
    readReg(3, "R12 register unchanged", sh[3]);

    // R13 start during a memory operation is ignored
    @(negedge clk);
    reqCount = 0;
    memLat = 4;
    modeCode = 4'd3; regA = 3'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    modeCode = 4'd7; regA = 3'd2; sizeLog2 = 2'd0; start = 1'b1;
    #1;
    check("R13 no done for start while busy", 32'(done), 32'd0);
    @(negedge clk);
    start = 1'b0;
    waitDone(seen);
    check("R13 original op completes", 32'(operand), 32'(memFn(sh[5])));
    check("R13 single request", 32'(reqCount), 32'd1);
    check("R13 no update from ignored start", 32'(wbEn), 32'd0);
    readReg(2, "R13 register untouched", sh[2]);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule